// File: doc/BRIEF.md
# Multi-channel synchronous reload controller

This block coordinates coefficient updates for a group of timer channels. Each channel keeps a staging (buffer) value and a live (active) compare value. Software writes the staging values whenever it likes. The controller decides when each staging value becomes live, so that related channels change together and never show a half-updated set of compare values.

A channel can run in one of two ways. With reload disabled, a staging write goes live at once. With reload enabled, the value is held until the channel's rewrite trigger fires. Each channel picks its trigger through its control bits. It can follow the master counter: either its count-start pulse or the peak of its triangular cycle. It can also follow the interrupt pulses of a set of channels that are marked as trigger sources.

Four control words, one bit per channel, are reached through a small register bus. Reads are always allowed. A write changes only the bits of channels whose counters are stopped.

Top module: `sync_reload_ctrl`

## Requirements
- R1: After reset, all four control words read as zero and every active value is zero.
- R2: The control word picked by `bus_addr` can be written and read back: 0 is reload enable, 1 is source select, 2 is timing mode and 3 is trigger-channel mark. `bus_rdata` shows the stored word at all times, whether or not channels are running.
- R3: A control write changes bit i only while `chan_run[i]` is 0. Bits of running channels keep their old value.
- R4: For a channel whose reload-enable bit is 0, a staging write makes the active value equal to the written data at the same clock edge. Master pulses and interrupt pulses never change that channel.
- R5: For an enabled channel with source select 0 and timing mode 0, a `start_pulse` copies the staging value into the active value at that edge. A staging write on its own leaves the active value unchanged.
- R6: For an enabled channel with source select 0 and timing mode 1, a `peak_pulse` copies the staging value. `start_pulse` is ignored, and in timing mode 0 `peak_pulse` is ignored.
- R7: For an enabled channel with source select 1, the trigger is the OR of `chan_irq[j]` over every j whose trigger-channel bit is 1. The timing-mode bit, `start_pulse` and `peak_pulse` have no effect on that channel.
- R8: When a staging write and a trigger land in the same cycle, the active value takes the staging value held before the write. The new value goes live at the next trigger.
- R9: Every channel whose trigger fires in a cycle updates at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| bus_wr | input | 1 | Control word write strobe |
| bus_addr | input | 2 | Control word select |
| bus_wdata | input | NCH | Control write data |
| bus_rdata | output | NCH | Selected control word |
| chan_run | input | NCH | Per-channel counter running flag (write lock) |
| buf_wr | input | 1 | Staging value write strobe |
| buf_ch | input | CW | Channel addressed by the staging write |
| buf_wdata | input | DW | Staging write data |
| start_pulse | input | 1 | Master counter start pulse |
| peak_pulse | input | 1 | Master triangular-wave peak pulse |
| chan_irq | input | NCH | Per-channel interrupt pulses |
| act_flat | output | NCH*DW | Active values, channel i at bits i*DW upward |

## Verification
The bench builds the block with four channels and 8-bit values. With this size, each control word has only 16 possible values, and a full control setting fits in 16 bits. A sweep over 1200 hashed settings therefore covers every per-channel combination of enable, source, mode and mark many times, under each kind of trigger and random interrupt patterns. Directed sequences cover the per-bit write lock, reads taken while channels run, and a staging write that collides with a trigger.

// File: rtl/reload_pkg.sv
package reload_pkg;
  typedef enum logic [1:0] {
    CTL_ENABLE = 2'd0,
    CTL_SOURCE = 2'd1,
    CTL_TIMING = 2'd2,
    CTL_MARK   = 2'd3
  } ctl_sel_e;
  localparam int NUM_CTL = 4;
endpackage

// File: rtl/reload_ctl_regs.sv
module reload_ctl_regs
  import reload_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [NCH-1:0] bus_wdata,
  input  logic [NCH-1:0] chan_run,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] src_o,
  output logic [NCH-1:0] mode_o,
  output logic [NCH-1:0] mark_o,
  output logic [NCH-1:0] rdata_o
);
  logic [NCH-1:0] ctl_q [NUM_CTL];
  logic [NCH-1:0] ctl_d [NUM_CTL];
  logic [NUM_CTL-1:0] ctl_we;

  for (genvar r = 0; r < NUM_CTL; r++) begin : g_ctl
    always_comb begin
      ctl_we[r] = bus_wr && (bus_addr == 2'(r));
      // stopped channels take the new bit, running channels keep theirs
      ctl_d[r]  = (bus_wdata & ~chan_run) | (ctl_q[r] & chan_run);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[r] <= '0;
      end else if (ctl_we[r]) begin
        ctl_q[r] <= ctl_d[r];
      end
    end
  end

  assign en_o    = ctl_q[CTL_ENABLE];
  assign src_o   = ctl_q[CTL_SOURCE];
  assign mode_o  = ctl_q[CTL_TIMING];
  assign mark_o  = ctl_q[CTL_MARK];
  assign rdata_o = ctl_q[bus_addr];
endmodule

// File: rtl/reload_trig_sel.sv
module reload_trig_sel #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] src_i,
  input  logic [NCH-1:0] mode_i,
  input  logic [NCH-1:0] mark_i,
  input  logic           start_i,
  input  logic           peak_i,
  input  logic [NCH-1:0] irq_i,
  output logic [NCH-1:0] fire_o
);
  logic chain_hit;
  assign chain_hit = |(irq_i & mark_i);

  for (genvar i = 0; i < NCH; i++) begin : g_fire
    logic master_evt;
    assign master_evt = mode_i[i] ? peak_i : start_i;
    assign fire_o[i]  = en_i[i] & (src_i[i] ? chain_hit : master_evt);
  end
endmodule

// File: rtl/reload_chan_bank.sv
module reload_chan_bank #(
  parameter int NCH = 16,
  parameter int DW  = 16,
  parameter int CW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  en_i,
  input  logic [NCH-1:0]  fire_i,
  input  logic            buf_wr,
  input  logic [CW-1:0]   buf_ch,
  input  logic [DW-1:0]   buf_wdata,
  output logic [NCH*DW-1:0] act_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit;
    logic          open_wr;
    logic          buf_we;
    logic          act_we;
    logic [DW-1:0] buf_q, buf_d;
    logic [DW-1:0] act_q, act_d;

    always_comb begin
      hit     = buf_wr && (buf_ch == CW'(i));
      open_wr = hit && !en_i[i];
      buf_we  = hit;
      buf_d   = buf_wdata;
      act_we  = open_wr || fire_i[i];
      // a trigger moves the value staged before this edge
      act_d   = open_wr ? buf_wdata : buf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q <= '0;
      end else if (buf_we) begin
        buf_q <= buf_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= '0;
      end else if (act_we) begin
        act_q <= act_d;
      end
    end

    assign act_flat[i*DW +: DW] = act_q;
  end
endmodule

// File: rtl/sync_reload_ctrl.sv
module sync_reload_ctrl #(
  parameter  int NCH = 16,
  parameter  int DW  = 16,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [NCH-1:0]    bus_wdata,
  output logic [NCH-1:0]    bus_rdata,
  input  logic [NCH-1:0]    chan_run,
  input  logic              buf_wr,
  input  logic [CW-1:0]     buf_ch,
  input  logic [DW-1:0]     buf_wdata,
  input  logic              start_pulse,
  input  logic              peak_pulse,
  input  logic [NCH-1:0]    chan_irq,
  output logic [NCH*DW-1:0] act_flat
);
  logic [NCH-1:0] en_q, src_q, mode_q, mark_q, fire;

  reload_ctl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .chan_run(chan_run),
    .en_o(en_q), .src_o(src_q), .mode_o(mode_q), .mark_o(mark_q),
    .rdata_o(bus_rdata)
  );

  reload_trig_sel #(.NCH(NCH)) u_trig (
    .en_i(en_q), .src_i(src_q), .mode_i(mode_q), .mark_i(mark_q),
    .start_i(start_pulse), .peak_i(peak_pulse), .irq_i(chan_irq),
    .fire_o(fire)
  );

  reload_chan_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .fire_i(fire),
    .buf_wr(buf_wr), .buf_ch(buf_ch), .buf_wdata(buf_wdata),
    .act_flat(act_flat)
  );
endmodule

// File: rtl/sync_reload_ctrl_chk.sv
module sync_reload_ctrl_chk #(
  parameter int NCH = 16,
  parameter int DW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [NCH-1:0]    chan_run,
  input logic              buf_wr,
  input logic [CW-1:0]     buf_ch,
  input logic [DW-1:0]     buf_wdata,
  input logic              start_pulse,
  input logic              peak_pulse,
  input logic [NCH-1:0]    chan_irq,
  input logic [NCH*DW-1:0] act_flat,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    src_q,
  input logic [NCH-1:0]    mode_q,
  input logic [NCH-1:0]    mark_q
);
  logic [CW-1:0] ch_d;
  logic [DW-1:0] dat_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_d  <= '0;
      dat_d <= '0;
    end else begin
      ch_d  <= buf_ch;
      dat_d <= buf_wdata;
    end
  end

  // R3: running channels keep their enable and mark bits across a write
  p_lock_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (((en_q ^ $past(en_q)) & $past(chan_run)) == '0));
  p_lock_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> (((mark_q ^ $past(mark_q)) & $past(chan_run)) == '0));
  // R2: no write strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(en_q) && $stable(src_q) && $stable(mode_q) && $stable(mark_q)));
  // R4: open channel takes write data at once
  p_open_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !en_q[buf_ch]) |=> (act_flat[ch_d*DW +: DW] == dat_d));
  // R5: nothing happening leaves every active value alone
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_wr && !start_pulse && !peak_pulse && chan_irq == '0) |=> $stable(act_flat));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R6: start-timed channel ignores a lone peak
    p_peak_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !src_q[i] && !mode_q[i] && !start_pulse)
      |=> $stable(act_flat[i*DW +: DW]));
    // R7: chained channel moves only on a marked interrupt
    p_chain_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && src_q[i] && (chan_irq & mark_q) == '0)
      |=> $stable(act_flat[i*DW +: DW]));
    // R4: open channel ignores every trigger
    p_open_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !(buf_wr && buf_ch == CW'(i)))
      |=> $stable(act_flat[i*DW +: DW]));
  end
endmodule

bind sync_reload_ctrl sync_reload_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .chan_run(chan_run), .buf_wr(buf_wr), .buf_ch(buf_ch),
  .buf_wdata(buf_wdata), .start_pulse(start_pulse), .peak_pulse(peak_pulse),
  .chan_irq(chan_irq), .act_flat(act_flat),
  .en_q(en_q), .src_q(src_q), .mode_q(mode_q), .mark_q(mark_q)
);

// File: tb/tb_sync_reload_ctrl.sv
`timescale 1ns/1ps
module tb_sync_reload_ctrl;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int CW  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [1:0] bus_addr;
  logic [NCH-1:0] bus_wdata, bus_rdata, chan_run, chan_irq;
  logic buf_wr, start_pulse, peak_pulse;
  logic [CW-1:0] buf_ch;
  logic [DW-1:0] buf_wdata;
  logic [NCH*DW-1:0] act_flat;

  always #2 clk = ~clk;

  sync_reload_ctrl #(.NCH(NCH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_run(chan_run),
    .buf_wr(buf_wr), .buf_ch(buf_ch), .buf_wdata(buf_wdata),
    .start_pulse(start_pulse), .peak_pulse(peak_pulse),
    .chan_irq(chan_irq), .act_flat(act_flat)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [NCH-1:0] m_ctl [4];
  logic [DW-1:0]  m_buf [NCH];
  logic [DW-1:0]  m_act [NCH];

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic check_act(string tag);
    for (int c = 0; c < NCH; c++) check(tag, 32'(act_flat[c*DW +: DW]), 32'(m_act[c]));
  endtask

  task automatic read_chk(logic [1:0] a, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, 32'(bus_rdata), 32'(m_ctl[a]));
  endtask

  task automatic bus_write(logic [1:0] a, logic [NCH-1:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    m_ctl[a] = (v & ~chan_run) | (m_ctl[a] & chan_run);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic buf_write(int ch, logic [DW-1:0] v);
    @(negedge clk);
    buf_wr = 1'b1; buf_ch = CW'(ch); buf_wdata = v;
    m_buf[ch] = v;
    if (!m_ctl[0][ch]) m_act[ch] = v;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  function automatic void model_fire(logic s, logic p, logic [NCH-1:0] irq);
    logic hit;
    hit = |(irq & m_ctl[3]);
    for (int c = 0; c < NCH; c++)
      if (m_ctl[0][c] && (m_ctl[1][c] ? hit : (m_ctl[2][c] ? p : s)))
        m_act[c] = m_buf[c];
  endfunction

  task automatic fire(logic s, logic p, logic [NCH-1:0] irq);
    @(negedge clk);
    start_pulse = s; peak_pulse = p; chan_irq = irq;
    model_fire(s, p, irq);
    @(negedge clk);
    start_pulse = 1'b0; peak_pulse = 1'b0; chan_irq = '0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; chan_run = 0;
    buf_wr = 0; buf_ch = 0; buf_wdata = 0; start_pulse = 0; peak_pulse = 0;
    chan_irq = 0;
    for (int r = 0; r < 4; r++) m_ctl[r] = '0;
    for (int c = 0; c < NCH; c++) begin m_buf[c] = '0; m_act[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) read_chk(2'(r), "R1 ctl reset");
    check_act("R1 act reset");

    // R2 write/read each word
    for (int r = 0; r < 4; r++) begin
      bus_write(2'(r), 4'(r * 5 + 3));
      read_chk(2'(r), "R2 readback");
    end

    // R3 lock per bit, R2 read while running
    chan_run = 4'b0101;
    bus_write(2'd0, 4'hF); read_chk(2'd0, "R3 lock set");
    bus_write(2'd0, 4'h0); read_chk(2'd0, "R3 lock clear");
    bus_write(2'd3, 4'hA); read_chk(2'd3, "R2 read running");
    chan_run = 4'b1111;
    bus_write(2'd1, 4'h0); read_chk(2'd1, "R3 all locked");
    chan_run = 4'b0000;

    // R8 collision: channel 0 enabled, start timed
    bus_write(2'd0, 4'h1); bus_write(2'd1, 4'h0); bus_write(2'd2, 4'h0);
    buf_write(0, 8'h11);
    check_act("R5 staged hold");
    @(negedge clk);
    buf_wr = 1'b1; buf_ch = 0; buf_wdata = 8'h22; start_pulse = 1'b1;
    m_act[0] = 8'h11; m_buf[0] = 8'h22;
    @(negedge clk);
    buf_wr = 1'b0; start_pulse = 1'b0;
    check(" R8 collision old", 32'(act_flat[DW-1:0]), 32'h11);
    fire(1'b1, 1'b0, '0);
    check(" R8 collision next", 32'(act_flat[DW-1:0]), 32'h22);

    // R9 all channels same edge
    bus_write(2'd0, 4'hF); bus_write(2'd1, 4'h0); bus_write(2'd2, 4'h0);
    for (int c = 0; c < NCH; c++) buf_write(c, 8'(8'h40 + c));
    fire(1'b1, 1'b0, '0);
    check_act("R9 joint update");

    // sweep: R4 R5 R6 R7 R9
    for (int n = 0; n < 1200; n++) begin
      logic [31:0] x;
      x = 32'(n) * 32'h9E3779B1 + 32'h1234567;
      x = x ^ (x >> 13);
      bus_write(2'd0, x[3:0]);
      bus_write(2'd1, x[7:4]);
      bus_write(2'd2, x[11:8]);
      bus_write(2'd3, x[15:12]);
      for (int e = 0; e < 3; e++) begin
        for (int c = 0; c < NCH; c++)
          buf_write(c, 8'(n * 7 + e * 13 + c * 29 + x[23:16]));
        check_act("R4 R5 staging write");
        case (e)
          0: fire(1'b1, 1'b0, '0);
          1: fire(1'b0, 1'b1, '0);
          default: fire(x[24], x[25], x[31:28]);
        endcase
        check_act("R5 R6 R7 trigger");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule